// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Access Sequencer

This block runs single asynchronous accesses on an external memory bus that shares its lines between address and data. A host starts an access with a one-cycle strobe that carries the address, the write data and a direction flag. The sequencer then steps through three phases in a fixed order: address setup, address hold and data. It drives chip enable, an address-valid strobe, output enable, write enable, and the shared bus with its drive enable. When the data phase is over it pulses done, and for a read it presents the captured word.

Four timing inputs set the length of each phase and of a recovery gap after the access, all counted in clock cycles. A write's data phase is one cycle longer than a read's. The external WAIT line has a selectable active level and can stretch the data phase only. It is honoured only while more than four data cycles are still to run. WAIT is not sampled during the address phases or near the end of the data phase. After chip enable rises it stays high for the programmed turnaround count plus one idle cycle before another access can begin.

Top module: `msq_mux_seq`

## Requirements
- R1: A start sampled high while the sequencer is idle begins an access in the next cycle, with mem_ce_n and mem_adv_n both low in that first cycle; the phases then run as address setup, address hold, data.
- R2: Address setup lasts cfg_setup cycles, where a value of 0 counts as 1. In those cycles mem_adv_n is low, mem_ad_oe is 1, and mem_ad_out carries the latched address.
- R3: Address hold follows for cfg_hold cycles (0 skips it). In those cycles mem_adv_n is high, the address stays driven, and mem_oe_n and mem_we_n are both high.
- R4: A read's data phase lasts cfg_data cycles, where 0 counts as 1. In it mem_oe_n is low and mem_ad_oe is 0. rdata takes mem_ad_in as sampled at the clock edge that ends the last data cycle.
- R5: A write's data phase lasts cfg_data+1 cycles. In it the bus is driven with the write data and mem_oe_n is high. mem_we_n is low in every data cycle except the last.
- R6: With cfg_wait_en at 1, a data cycle in which WAIT is at its active level and more than 4 data cycles remain is repeated without counting down. With cfg_wait_en at 0, WAIT has no effect.
- R7: cfg_wait_pol at 1 makes WAIT active high; cfg_wait_pol at 0 makes it active low.
- R8: WAIT seen in a data cycle with 4 or fewer cycles remaining does not lengthen the access.
- R9: WAIT never lengthens the address setup or address hold phase.
- R10: done is high for exactly one cycle: the cycle after the last data cycle. mem_ce_n is high in that cycle, and for a read rdata already holds the captured word.
- R11: After the data phase, mem_ce_n stays high for cfg_turn cycles plus one idle cycle. With start held high, the next access lowers mem_ce_n after exactly cfg_turn+1 high cycles.
- R12: A start seen while an access or the turnaround gap is in progress is dropped and does not produce a later access.
- R13: While reset is applied, all strobes are high, mem_ad_oe is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, taken only when idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| cfg_setup | input | 4 | Address setup cycles |
| cfg_hold | input | 4 | Address hold cycles |
| cfg_data | input | 8 | Data phase cycles (read) |
| cfg_turn | input | 4 | Turnaround cycles |
| cfg_wait_en | input | 1 | Enables WAIT stretching |
| cfg_wait_pol | input | 1 | WAIT active level |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ad_out | output | 16 | Shared bus outgoing value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_in | input | 16 | Shared bus incoming value |
| mem_wait | input | 1 | WAIT from memory |

## Verification
The assertions assume that WAIT is already synchronous to clk. They also assume that cfg_turn keeps its value from the end of a data phase until the next chip enable fall, since the gap check compares against the value seen when chip enable rose. The stimulus changes WAIT and the configuration only at falling clock edges. It reprograms the turnaround count only after the sequencer has been idle for longer than any gap, and it keeps every WAIT window finite so that every stretched data phase ends.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TURN  = 3'd4
  } msq_phase_e;
endpackage

// File: rtl/msq_rst_sync.sv
module msq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  // assertion is immediate, release walks through the chain
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/msq_wait_qual.sv
module msq_wait_qual #(
  parameter int REM_W = 9,
  parameter int LEAD  = 4
) (
  input  logic             wait_in,
  input  logic             wait_en,
  input  logic             wait_pol,
  input  logic             in_data,
  input  logic [REM_W-1:0] rem,
  output logic             stall
);
  localparam logic [REM_W-1:0] LEAD_V = REM_W'(LEAD);

  logic level_active;
  logic in_window;

  // polarity 1: high means wait; polarity 0: low means wait
  assign level_active = wait_pol ? wait_in : ~wait_in;
  // only cycles with more than LEAD cycles left may be stretched
  assign in_window    = (rem > LEAD_V);
  assign stall        = in_data & wait_en & level_active & in_window;
endmodule

// File: rtl/msq_phase_ctrl.sv
module msq_phase_ctrl
  import msq_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int HLD_W = 4,
  parameter int DAT_W = 8,
  parameter int TRN_W = 4,
  parameter int REM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [SET_W-1:0] cfg_setup,
  input  logic [HLD_W-1:0] cfg_hold,
  input  logic [DAT_W-1:0] cfg_data,
  input  logic [TRN_W-1:0] cfg_turn,
  input  logic             stall,
  output msq_phase_e       phase,
  output logic [REM_W-1:0] rem,
  output logic             last,
  output logic             accept,
  output logic             data_end
);
  localparam logic [REM_W-1:0] ONE = REM_W'(1);

  msq_phase_e       phase_q, phase_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [REM_W-1:0] setup_len, hold_len, data_len, turn_len;
  logic             tick_en;

  // phase lengths, with the minimums the access timing needs
  always_comb begin
    setup_len = (cfg_setup == '0) ? ONE : REM_W'(cfg_setup);
    hold_len  = REM_W'(cfg_hold);
    turn_len  = REM_W'(cfg_turn);
    if (is_write)
      data_len = REM_W'(cfg_data) + ONE;
    else
      data_len = (cfg_data == '0) ? ONE : REM_W'(cfg_data);
  end

  assign last     = (rem_q == ONE);
  assign accept   = (phase_q == PH_IDLE) && start;
  assign data_end = (phase_q == PH_DATA) && last && !stall;
  assign tick_en  = ((phase_q != PH_IDLE) || start) && !stall;

  always_comb begin
    phase_d = phase_q;
    rem_d   = rem_q - ONE;
    unique case (phase_q)
      PH_IDLE: begin
        rem_d = rem_q;
        if (start) begin
          phase_d = PH_SETUP;
          rem_d   = setup_len;
        end
      end
      PH_SETUP: begin
        if (last) begin
          if (hold_len != '0) begin
            phase_d = PH_HOLD;
            rem_d   = hold_len;
          end else begin
            phase_d = PH_DATA;
            rem_d   = data_len;
          end
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_DATA;
          rem_d   = data_len;
        end
      end
      PH_DATA: begin
        if (last) begin
          if (turn_len != '0) begin
            phase_d = PH_TURN;
            rem_d   = turn_len;
          end else begin
            phase_d = PH_IDLE;
            rem_d   = '0;
          end
        end
      end
      PH_TURN: begin
        if (last) begin
          phase_d = PH_IDLE;
          rem_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        rem_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rem_q   <= '0;
    end else if (tick_en) begin
      phase_q <= phase_d;
      rem_q   <= rem_d;
    end
  end

  assign phase = phase_q;
  assign rem   = rem_q;
endmodule

// File: rtl/msq_bus_drv.sv
module msq_bus_drv
  import msq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  msq_phase_e       phase,
  input  logic             last,
  input  logic             data_end,
  input  logic [BUS_W-1:0] mem_ad_in,
  output logic             is_write,
  output logic             mem_ce_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [BUS_W-1:0] mem_ad_out,
  output logic             mem_ad_oe,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;
  logic             wr_q, done_q;
  logic             ph_setup, ph_hold, ph_data;
  logic             cap_en;

  // request is latched once, on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  assign cap_en = data_end && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (cap_en) rdata_q <= mem_ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= data_end;
  end

  assign ph_setup = (phase == PH_SETUP);
  assign ph_hold  = (phase == PH_HOLD);
  assign ph_data  = (phase == PH_DATA);

  assign mem_ce_n   = ~(ph_setup | ph_hold | ph_data);
  assign mem_adv_n  = ~ph_setup;
  assign mem_ad_oe  = ph_setup | ph_hold | (ph_data & wr_q);
  assign mem_ad_out = ph_data ? wdata_q : addr_q;
  assign mem_oe_n   = ~(ph_data & ~wr_q);
  assign mem_we_n   = ~(ph_data & wr_q & ~last);

  assign is_write = wr_q;
  assign done     = done_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/msq_mux_seq.sv
module msq_mux_seq
  import msq_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int SET_W     = 4,
  parameter int HLD_W     = 4,
  parameter int DAT_W     = 8,
  parameter int TRN_W     = 4,
  parameter int WAIT_LEAD = 4,
  parameter int RST_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  input  logic [SET_W-1:0] cfg_setup,
  input  logic [HLD_W-1:0] cfg_hold,
  input  logic [DAT_W-1:0] cfg_data,
  input  logic [TRN_W-1:0] cfg_turn,
  input  logic             cfg_wait_en,
  input  logic             cfg_wait_pol,
  output logic             mem_ce_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [BUS_W-1:0] mem_ad_out,
  output logic             mem_ad_oe,
  input  logic [BUS_W-1:0] mem_ad_in,
  input  logic             mem_wait
);
  localparam int W_SH  = (SET_W > HLD_W) ? SET_W : HLD_W;
  localparam int W_SHT = (W_SH > TRN_W) ? W_SH : TRN_W;
  localparam int REM_W = (W_SHT > DAT_W + 1) ? W_SHT : DAT_W + 1;

  logic             rst_n_int;
  msq_phase_e       phase;
  logic [REM_W-1:0] rem;
  logic             last, accept, data_end, stall, is_write;

  msq_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  msq_wait_qual #(.REM_W(REM_W), .LEAD(WAIT_LEAD)) u_wait (
    .wait_in  (mem_wait),
    .wait_en  (cfg_wait_en),
    .wait_pol (cfg_wait_pol),
    .in_data  (phase == PH_DATA),
    .rem      (rem),
    .stall    (stall)
  );

  msq_phase_ctrl #(
    .SET_W(SET_W), .HLD_W(HLD_W), .DAT_W(DAT_W), .TRN_W(TRN_W), .REM_W(REM_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (req_start),
    .is_write  (is_write),
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .cfg_data  (cfg_data),
    .cfg_turn  (cfg_turn),
    .stall     (stall),
    .phase     (phase),
    .rem       (rem),
    .last      (last),
    .accept    (accept),
    .data_end  (data_end)
  );

  msq_bus_drv #(.BUS_W(BUS_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .phase      (phase),
    .last       (last),
    .data_end   (data_end),
    .mem_ad_in  (mem_ad_in),
    .is_write   (is_write),
    .mem_ce_n   (mem_ce_n),
    .mem_adv_n  (mem_adv_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ad_out (mem_ad_out),
    .mem_ad_oe  (mem_ad_oe),
    .done       (done),
    .rdata      (rdata)
  );
endmodule

// File: rtl/msq_mux_seq_chk.sv
module msq_mux_seq_chk #(
  parameter int TRN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_ce_n,
  input logic             mem_adv_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_ad_oe,
  input logic             done,
  input logic [TRN_W-1:0] cfg_turn
);
  logic [TRN_W+1:0] hi_cnt;
  logic [TRN_W-1:0] turn_q;
  logic             ce_q, seen;

  // length of the current run of high chip-enable cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      ce_q   <= 1'b1;
      seen   <= 1'b0;
      turn_q <= '0;
    end else begin
      ce_q <= mem_ce_n;
      if (!mem_ce_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (mem_ce_n && !ce_q) begin
        turn_q <= cfg_turn;
        seen   <= 1'b1;
      end
    end
  end

  assert_reset_idle_R13: assert property (@(posedge clk)
    !rst_n |-> (mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_ad_oe && !done));

  assert_begin_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> !mem_adv_n);

  assert_addr_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_ad_oe && !mem_ce_n && mem_oe_n && mem_we_n));

  assert_adv_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n) && $past(mem_adv_n)) |-> mem_adv_n);

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ad_oe && !mem_ce_n && mem_we_n));

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_ad_oe && !mem_ce_n && mem_oe_n));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_ce_n);

  assert_turn_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(mem_ce_n)) |-> (hi_cnt > {2'b00, turn_q}));
endmodule

bind msq_mux_seq msq_mux_seq_chk #(.TRN_W(TRN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .mem_ce_n  (mem_ce_n),
  .mem_adv_n (mem_adv_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ad_oe (mem_ad_oe),
  .done      (done),
  .cfg_turn  (cfg_turn)
);

// File: tb/msq_mux_seq_tb.sv
`timescale 1ns/1ps
module msq_mux_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        done;
  logic [15:0] rdata;
  logic [3:0]  cfg_setup, cfg_hold, cfg_turn;
  logic [7:0]  cfg_data;
  logic        cfg_wait_en, cfg_wait_pol;
  logic        mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe;
  logic [15:0] mem_ad_out, mem_ad_in;
  logic        mem_wait;

  int  nvec = 0;
  int  nbad = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  msq_mux_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_data(cfg_data),
    .cfg_turn(cfg_turn), .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe),
    .mem_ad_in(mem_ad_in), .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected data-phase length from R4/R5/R6/R8: window [j, j+k) in data cycles
  function automatic int data_cycles(bit wr, int dcfg, bit en, int j, int k);
    int r = wr ? dcfg + 1 : ((dcfg == 0) ? 1 : dcfg);
    int d = 0;
    while (1) begin
      if (en && d >= j && d < j + k && r > 4) d++;
      else if (r == 1) return d + 1;
      else begin r--; d++; end
    end
  endfunction

  function automatic int base_len(bit wr, int dcfg);
    return wr ? dcfg + 1 : ((dcfg == 0) ? 1 : dcfg);
  endfunction

  task automatic idle_outputs(input string when);
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_ad_oe && !done,
        "R13", when, {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe, done}, 6'b111100);
  endtask

  task automatic run_access(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                            input logic [15:0] rval, input int j, input int k,
                            input bit mid, input bit chained, input string tag);
    int sp = (cfg_setup == 0) ? 1 : int'(cfg_setup);
    int hp = int'(cfg_hold);
    int dp = data_cycles(wr, int'(cfg_data), cfg_wait_en, j, k);
    int gap = 0, idx = 0, adv_cnt = 0, str_cnt = 0, done_early = 0, didx;
    int exp_gap = chained ? int'(cfg_turn) : 0;
    bit setup_ok = 1, hold_ok = 1, data_ok = 1;
    req_write = wr; req_addr = addr; req_wdata = wdata; req_start = 1'b1;
    @(negedge clk);
    while (mem_ce_n && gap < 60) begin gap++; @(negedge clk); end
    req_start = 1'b0;
    while (!mem_ce_n && idx < 400) begin
      didx = idx - sp - hp;
      mem_wait  = (didx >= j && didx < j + k) ? cfg_wait_pol : ~cfg_wait_pol;
      mem_ad_in = (didx == dp - 1) ? rval : ~rval;
      if (done) done_early++;
      if (!mem_adv_n) begin
        adv_cnt++;
        if (!(mem_ad_oe && mem_ad_out == addr && idx < sp)) setup_ok = 0;
      end else if (idx < sp + hp) begin
        if (!(mem_ad_oe && mem_ad_out == addr && mem_oe_n && mem_we_n)) hold_ok = 0;
      end else if (wr) begin
        if (!mem_we_n) str_cnt++;
        if (!(mem_ad_oe && mem_ad_out == wdata && mem_oe_n)) data_ok = 0;
      end else begin
        if (!mem_oe_n) str_cnt++;
        if (mem_ad_oe || !mem_we_n) data_ok = 0;
      end
      if (mid && idx == 1) begin req_start = 1'b1; req_addr = ~addr; end
      if (mid && idx == 2) req_start = 1'b0;
      idx++;
      @(negedge clk);
    end
    req_start = 1'b0;
    mem_wait  = ~cfg_wait_pol;
    chk(gap == exp_gap, chained ? "R11" : "R1", "high cycles before enable", gap, exp_gap);
    chk(adv_cnt == sp, "R2", "setup length", adv_cnt, sp);
    chk(setup_ok, "R2", "address on bus in setup", 0, 1);
    chk(hold_ok, "R3", "address held, strobes idle", 0, 1);
    chk(idx == sp + hp + dp, tag, "enable-low length", idx, sp + hp + dp);
    chk(str_cnt == (wr ? dp - 1 : dp), wr ? "R5" : "R4", "strobe cycles",
        str_cnt, wr ? dp - 1 : dp);
    chk(data_ok, wr ? "R5" : "R4", "bus use in data phase", 0, 1);
    chk(done && done_early == 0, "R10", "done timing", {31'd0, done} + done_early * 2, 1);
    if (!wr) chk(rdata == rval, "R4", "read capture", int'(rdata), int'(rval));
  endtask

  task automatic set_cfg(input int s, input int h, input int d, input int t,
                         input bit en, input bit pol);
    cfg_setup = 4'(s); cfg_hold = 4'(h); cfg_data = 8'(d); cfg_turn = 4'(t);
    cfg_wait_en = en; cfg_wait_pol = pol; mem_wait = ~pol;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_ad_in = '0;
    set_cfg(1, 0, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    idle_outputs("outputs during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_outputs("outputs after reset");

    // minimum lengths: setup 0 acts as 1, data 0 acts as 1 for reads
    set_cfg(0, 0, 0, 0, 0, 1);
    run_access(1'b0, 16'h1234, 16'h0, 16'hBEEF, 0, 0, 0, 0, "R4");
    repeat (20) @(negedge clk);
    run_access(1'b1, 16'h4321, 16'hCAFE, 16'h0, 0, 0, 0, 0, "R5");
    repeat (20) @(negedge clk);

    // stretch inside the window, active high
    set_cfg(3, 2, 10, 2, 1, 1);
    run_access(1'b0, 16'hA001, 16'h0, 16'h5A5A, 1, 4, 0, 0, "R6");
    repeat (20) @(negedge clk);
    // same with active-low WAIT
    set_cfg(3, 2, 10, 2, 1, 0);
    run_access(1'b0, 16'hA002, 16'h0, 16'hA5A5, 1, 4, 0, 0, "R7");
    repeat (20) @(negedge clk);
    // WAIT disabled: active level has no effect
    set_cfg(3, 2, 10, 2, 0, 1);
    run_access(1'b1, 16'hA003, 16'h7777, 16'h0, 0, 6, 0, 0, "R6");
    repeat (20) @(negedge clk);
    // late WAIT with 4 cycles left is ignored
    set_cfg(3, 2, 10, 2, 1, 1);
    run_access(1'b0, 16'hA004, 16'h0, 16'h1111, 6, 3, 0, 0, "R8");
    repeat (20) @(negedge clk);
    // 5 cycles left is still inside the window
    run_access(1'b0, 16'hA005, 16'h0, 16'h2222, 5, 2, 0, 0, "R6");
    repeat (20) @(negedge clk);
    // WAIT only during the address phases
    run_access(1'b1, 16'hA006, 16'h3333, 16'h0, -5, 5, 0, 0, "R9");
    repeat (20) @(negedge clk);

    // back-to-back with a turnaround of 5
    set_cfg(2, 1, 4, 5, 0, 1);
    run_access(1'b0, 16'hB001, 16'h0, 16'h4444, 0, 0, 0, 0, "R4");
    run_access(1'b1, 16'hB002, 16'h5555, 16'h0, 0, 0, 0, 1, "R11");
    repeat (20) @(negedge clk);

    // start during an access is dropped
    set_cfg(2, 1, 4, 3, 0, 1);
    run_access(1'b1, 16'hC001, 16'h6666, 16'h0, 0, 0, 1, 0, "R5");
    begin
      int low_seen = 0;
      for (int c = 0; c < 30; c++) begin
        if (!mem_ce_n) low_seen++;
        @(negedge clk);
      end
      chk(low_seen == 0, "R12", "cycles with enable low after dropped start", low_seen, 0);
    end

    // constrained random accesses
    for (int n = 0; n < 60; n++) begin
      bit chained = (n > 0) && ($urandom_range(0, 1) == 1);
      bit wr = $urandom_range(0, 1) == 1;
      int d = $urandom_range(0, 24);
      int b = base_len(wr, d);
      int j = $urandom_range(0, b + 8) - 8;
      int k = $urandom_range(0, 10);
      int t = chained ? int'(cfg_turn) : $urandom_range(0, 15);
      if (!chained) repeat (20) @(negedge clk);
      set_cfg($urandom_range(0, 15), $urandom_range(0, 15), d, t,
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      run_access(wr, 16'($urandom), 16'($urandom), 16'($urandom), j, k, 0, chained,
                 wr ? "R5" : "R4");
    end

    repeat (20) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule